// File: doc/BRIEF.md
# Memory-Mapped Bidirectional Port

This block is a small general-purpose pin port for a simple processor bus. Software sees three 4-bit registers at byte addresses. The first sets the direction of each pin, the second enables each pin's pull-up, and the third holds the pin data. Bit n of each register belongs to pin n.

On the pad side, the block drives an output enable, an output value and a pull-up enable for each pin. It takes the pad's input level back through a two-flop synchronizer.

A read of the data register mixes two sources bit by bit:
- an output pin returns the value that was written to it;
- an input pin returns its synchronized pad level.

The data register can be loaded while a pin is still an input. The pin then drives that value as soon as it becomes an output.

Top module: `mmio_port`

## Requirements
- R1: While reset is asserted, and until the first write after it, every direction bit is 0 (input), every pull-up bit is 1 and every data bit is 0. The pads therefore show output enable 0000, output value 0000 and pull-up enable 1111.
- R2: The direction register is at address 0xB0 and can be read and written. A direction bit of 1 makes the pin an output and 0 makes it an input. The pad output enable of pin n equals direction bit n.
- R3: The pull-up register is at address 0xB1 and can be read and written. Pull-up bit n set to 1 requests a pull-up on pin n, and 0 turns it off.
- R4: The data register is at address 0xB2. The pad output value of pin n always equals data bit n: 1 drives high and 0 drives low.
- R5: The data register can be written while a pin is an input. Once the pin is switched to output, the stored value appears on its pad.
- R6: A read of 0xB2 returns data bit n for each output pin and the synchronized pad level for each input pin.
- R7: The pull-up enable of pin n is 1 only when pin n is an input and its pull-up bit is 1. For an output pin it is 0, whatever the pull-up bit holds.
- R8: A pad input change shows up in a data read after exactly two rising clock edges, and not after one.
- R9: Read data is 0 when the read strobe is low, and 0 for a read of any address other than 0xB0, 0xB1 or 0xB2.
- R10: A write takes effect at the next rising clock edge and not before. A write to an unmapped address changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, combinational from address and strobe |
| pad_in_i | input | 4 | Pad input levels, asynchronous |
| pad_out_o | output | 4 | Pad output values |
| pad_oe_o | output | 4 | Pad output enables, 1 = driving |
| pad_pu_o | output | 4 | Pad pull-up enables |

## Verification
The mixed data read is tried with the directions 1100 and 0011, each against stored data 1010 and pad levels 0101. Because the stored and pad values differ in every bit, each result shows which source fed each bit.

The pull-up gate is tried with direction and pull-up patterns that overlap in only some bits. This separates the AND-with-input rule from a plain copy of the pull-up register.

A walking pad change is read after one edge and then after two, which tells a correct two-stage synchronizer from a one-stage one or a missing one. Stray writes and reads to the addresses next to the mapped ones check that address decoding is exact.

// File: rtl/mport_pkg.sv
package mport_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PUL  = 2'd2,
    SEL_DAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 3;
endpackage

// File: rtl/mport_decode.sv
module mport_decode
  import mport_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'hB0,
  parameter logic [ADDR_W-1:0] PUL_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'hB2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      DIR_ADDR: sel_o = SEL_DIR;
      PUL_ADDR: sel_o = SEL_PUL;
      DAT_ADDR: sel_o = SEL_DAT;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/mport_regs.sv
module mport_regs
  import mport_pkg::*;
#(
  parameter int unsigned PIN_W = 4,
  parameter logic [PIN_W-1:0] DIR_RST = '0,
  parameter logic [PIN_W-1:0] PUL_RST = '1,
  parameter logic [PIN_W-1:0] DAT_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] dir_o,
  output logic [PIN_W-1:0] pul_o,
  output logic [PIN_W-1:0] dat_o
);
  logic [PIN_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam reg_sel_e MY_SEL = (g == 0) ? SEL_DIR : (g == 1) ? SEL_PUL : SEL_DAT;
    localparam logic [PIN_W-1:0] MY_RST = (g == 0) ? DIR_RST : (g == 1) ? PUL_RST : DAT_RST;
    logic wen;
    assign wen = wr_i && (sel_i == MY_SEL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[g] <= MY_RST;
      else if (wen) regs_q[g] <= wdata_i;
    end
  end

  assign dir_o = regs_q[0];
  assign pul_o = regs_q[1];
  assign dat_o = regs_q[2];
endmodule

// File: rtl/mport_sync.sv
module mport_sync #(
  parameter int unsigned PIN_W  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] async_i,
  output logic [PIN_W-1:0] sync_o
);
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_i[p];
      else chain_q <= {chain_q[STAGES-2:0], async_i[p]};
    end
    assign sync_o[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mport_rdmux.sv
module mport_rdmux
  import mport_pkg::*;
#(
  parameter int unsigned PIN_W = 4
) (
  input  logic             rd_i,
  input  reg_sel_e         sel_i,
  input  logic [PIN_W-1:0] dir_i,
  input  logic [PIN_W-1:0] pul_i,
  input  logic [PIN_W-1:0] dat_i,
  input  logic [PIN_W-1:0] pad_sync_i,
  output logic [PIN_W-1:0] rdata_o
);
  logic [PIN_W-1:0] port_view;
  // per-bit source: latch for outputs, pad for inputs
  assign port_view = (dat_i & dir_i) | (pad_sync_i & ~dir_i);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_DIR: rdata_o = dir_i;
        SEL_PUL: rdata_o = pul_i;
        SEL_DAT: rdata_o = port_view;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_port.sv
module mmio_port
  import mport_pkg::*;
#(
  parameter int unsigned PIN_W       = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'hB0,
  parameter logic [ADDR_W-1:0] PUL_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'hB2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PIN_W-1:0]  wdata_i,
  output logic [PIN_W-1:0]  rdata_o,
  input  logic [PIN_W-1:0]  pad_in_i,
  output logic [PIN_W-1:0]  pad_out_o,
  output logic [PIN_W-1:0]  pad_oe_o,
  output logic [PIN_W-1:0]  pad_pu_o
);
  reg_sel_e         sel;
  logic [PIN_W-1:0] dir_q, pul_q, dat_q, pad_sync;

  mport_decode #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .PUL_ADDR(PUL_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_decode (
    .addr_i(addr_i), .sel_o(sel)
  );

  mport_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel), .wdata_i(wdata_i),
    .dir_o(dir_q), .pul_o(pul_q), .dat_o(dat_q)
  );

  mport_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pad_in_i), .sync_o(pad_sync)
  );

  mport_rdmux #(.PIN_W(PIN_W)) u_rdmux (
    .rd_i(rd_i), .sel_i(sel), .dir_i(dir_q), .pul_i(pul_q), .dat_i(dat_q),
    .pad_sync_i(pad_sync), .rdata_o(rdata_o)
  );

  assign pad_oe_o  = dir_q;
  assign pad_out_o = dat_q;
  assign pad_pu_o  = pul_q & ~dir_q;
endmodule

// File: rtl/mport_chk.sv
module mport_chk #(
  parameter int unsigned PIN_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'hB0,
  parameter logic [ADDR_W-1:0] PUL_ADDR = 8'hB1,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'hB2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [PIN_W-1:0]  wdata_i,
  input logic [PIN_W-1:0]  rdata_o,
  input logic [PIN_W-1:0]  pad_out_o,
  input logic [PIN_W-1:0]  pad_oe_o,
  input logic [PIN_W-1:0]  pad_pu_o
);
  logic mapped;
  assign mapped = (addr_i == DIR_ADDR) || (addr_i == PUL_ADDR) || (addr_i == DAT_ADDR);

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == DIR_ADDR) |=> pad_oe_o == $past(wdata_i));

  a_r4_dat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == DAT_ADDR) |=> pad_out_o == $past(wdata_i));

  a_r7_no_pull_when_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);

  a_r6_out_pins_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == DAT_ADDR) |-> ((rdata_o ^ pad_out_o) & pad_oe_o) == '0);

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |-> rdata_o == '0);

  a_r10_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mapped) |=> ($stable(pad_oe_o) && $stable(pad_out_o) && $stable(pad_pu_o)));
endmodule

bind mmio_port mport_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W),
  .DIR_ADDR(DIR_ADDR), .PUL_ADDR(PUL_ADDR), .DAT_ADDR(DAT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_out_o(pad_out_o),
  .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o)
);

// File: tb/sim_mmio_port.sv
`timescale 1ns/1ps
module sim_mmio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic [3:0] pad_in_i = '0;
  logic [3:0] pad_out_o, pad_oe_o, pad_pu_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mmio_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o)
  );

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [3:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = '0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [3:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0; addr_i = '0;
  endtask

  task automatic t_reset();
    logic [3:0] d;
    check("R1", "oe at reset", pad_oe_o, 4'b0000);
    check("R1", "out at reset", pad_out_o, 4'b0000);
    check("R1", "pu at reset", pad_pu_o, 4'b1111);
    bus_read(8'hB0, d); check("R1", "dir readback", d, 4'b0000);
    bus_read(8'hB1, d); check("R1", "pull readback", d, 4'b1111);
    bus_read(8'hB2, d); check("R1", "data read", d, 4'b0000);
  endtask

  task automatic t_dir_pull();
    logic [3:0] d;
    bus_write(8'hB0, 4'b0101);
    check("R2", "oe after dir write", pad_oe_o, 4'b0101);
    check("R7", "pu gated by dir", pad_pu_o, 4'b1010);
    bus_read(8'hB0, d); check("R2", "dir readback", d, 4'b0101);
    bus_write(8'hB1, 4'b0011);
    bus_read(8'hB1, d); check("R3", "pull readback", d, 4'b0011);
    check("R7", "pu = pull and input", pad_pu_o, 4'b0010);
    bus_write(8'hB1, 4'b0000);
    check("R3", "pull off", pad_pu_o, 4'b0000);
    bus_write(8'hB1, 4'b1111);
    bus_write(8'hB0, 4'b0000);
  endtask

  task automatic t_data_preload();
    bus_write(8'hB2, 4'b1010);
    check("R4", "out follows data in input mode", pad_out_o, 4'b1010);
    check("R5", "still not driving", pad_oe_o, 4'b0000);
    bus_write(8'hB0, 4'b1111);
    check("R5", "oe after switch", pad_oe_o, 4'b1111);
    check("R5", "preloaded value on pad", pad_out_o, 4'b1010);
    check("R7", "no pull when all out", pad_pu_o, 4'b0000);
  endtask

  task automatic t_mixed_read();
    logic [3:0] d;
    pad_in_i = 4'b0101;
    bus_write(8'hB2, 4'b1010);
    bus_write(8'hB0, 4'b1100);
    repeat (3) @(negedge clk_i);
    bus_read(8'hB2, d); check("R6", "dir 1100 mixed read", d, 4'b1001);
    bus_write(8'hB0, 4'b0011);
    bus_read(8'hB2, d); check("R6", "dir 0011 mixed read", d, 4'b0110);
    bus_write(8'hB0, 4'b0000);
  endtask

  task automatic t_sync_lag();
    logic [3:0] d;
    pad_in_i = 4'b0000;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      pad_in_i = 4'b0001 << i;
      @(negedge clk_i);   // one edge since change
      addr_i = 8'hB2; rd_i = 1'b1;
      #1 check("R8", "after one edge", rdata_o, 4'b0001 << i >> 1 | ((i == 0) ? 4'b0000 : 4'b0000) | prev(i));
      rd_i = 1'b0;
      @(negedge clk_i);   // two edges
      addr_i = 8'hB2; rd_i = 1'b1;
      #1 check("R8", "after two edges", rdata_o, 4'b0001 << i);
      rd_i = 1'b0; addr_i = '0;
    end
    pad_in_i = 4'b0000;
    repeat (3) @(negedge clk_i);
    bus_read(8'hB2, d); check("R8", "settled low", d, 4'b0000);
  endtask

  function automatic logic [3:0] prev(int i);
    return (i == 0) ? 4'b0000 : (4'b0001 << (i - 1));
  endfunction

  task automatic t_unmapped();
    logic [3:0] d;
    bus_write(8'hB0, 4'b0110);
    bus_write(8'hB2, 4'b0011);
    bus_read(8'hB3, d); check("R9", "read 0xB3", d, 4'b0000);
    bus_read(8'hAF, d); check("R9", "read 0xAF", d, 4'b0000);
    @(negedge clk_i);
    addr_i = 8'hB0; rd_i = 1'b0;
    #1 check("R9", "no strobe", rdata_o, 4'b0000);
    bus_write(8'hB3, 4'b1111);
    bus_write(8'h30, 4'b1001);
    check("R10", "oe after stray", pad_oe_o, 4'b0110);
    check("R10", "out after stray", pad_out_o, 4'b0011);
    check("R10", "pu after stray", pad_pu_o, 4'b1001);
    bus_read(8'hB1, d); check("R10", "pull reg after stray", d, 4'b1111);
  endtask

  task automatic t_write_timing();
    @(negedge clk_i);
    addr_i = 8'hB2; wdata_i = 4'b1100; wr_i = 1'b1;
    #1 check("R10", "no change before edge", pad_out_o, 4'b0011);
    @(posedge clk_i);
    #1 check("R10", "change after edge", pad_out_o, 4'b1100);
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_dir_pull();
    t_data_preload();
    bus_write(8'hB0, 4'b0000);
    t_mixed_read();
    t_sync_lag();
    t_unmapped();
    t_write_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule